// File: doc/BRIEF.md
# Block Transfer DMA Engine

This engine moves one block of bytes between a 16-bit host memory port and an expansion memory port with a 24-bit address. A register front end supplies the operation code, the base addresses, the expansion bank, the byte count and the address-hold controls, and then pulses `start`. The engine supports four operations: copy host to expansion, copy expansion to host, exchange, and compare. Both memory ports are simple synchronous single-cycle ports, and read data returns on the cycle after the read strobe.

When the block is finished, the engine raises `done` for exactly one cycle. During that cycle it presents write-back values for the host address, the expansion address and bank, and the length. It also presents end-of-block, verify-error and interrupt strobes. The register front end uses `done` to clear its execute bit.

When autoload is set, the write-back values are the shadow copies instead of the final counters. The expansion address space is limited to the installed size, set by `EXP_SIZE_LOG2`, so bank bits above that size are dropped and the address wraps inside the installed memory.

Top module: `blk_dma_engine`

## Requirements
- R1: A `start` pulse while idle runs a transfer. `op_sel` 2'b00 copies `xfer_len` bytes from host memory to expansion memory, and 2'b01 copies from expansion memory to host memory.
- R2: `op_sel` 2'b10 exchanges the bytes of the two memories. Each byte takes one expansion write followed in the next cycle by one host write, so an N-byte exchange makes N writes on each port.
- R3: `op_sel` 2'b11 compares the bytes without writing either memory. If every byte matches, the end-of-block strobe is given and the verify-error strobe is not.
- R4: In compare mode, the first mismatching byte gives the verify-error strobe without end-of-block and stops the transfer with no further reads. Both write-back addresses then point one past the mismatching byte, and the length write-back equals the bytes not yet compared (1 when none remain).
- R5: An `xfer_len` of 0 stands for 65536 bytes.
- R6: `host_fix` holds the host address and `exp_fix` holds the expansion address. Otherwise each address steps by one per byte, and the host address wraps from 0xFFFF to 0x0000.
- R7: The expansion address is {`exp_bank`, `exp_base`} reduced to its low `EXP_SIZE_LOG2` bits (19 by default, keeping bank bits 2:0). It wraps to 0 within that size.
- R8: Without autoload, the `done` cycle gives `wb_host_we` = not `host_fix` with the final host address, and `wb_exp_we` = not `exp_fix` with the final expansion address low half and bank. It also gives `wb_len_we` = 1 with a length of 1 after a completed block.
- R9: With `autoload` set, all three write-back enables are 1 and the values are `sh_host`, `sh_exp`, `sh_bank` and `sh_len`.
- R10: `done` lasts one cycle and `busy` is low after it. A `start` pulse while busy is ignored, including the operation code that comes with it.
- R11: `irq_set` is given in the `done` cycle when end-of-block occurs with `irq_en` and `irq_eob_en` both set, or when a verify error occurs with `irq_en` and `irq_verr_en` both set. It is not given otherwise.
- R12: After reset the engine is idle. `busy` and `done` are low and no memory strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| op_sel | input | 2 | Operation code |
| autoload | input | 1 | Restore shadow values at the end |
| host_fix | input | 1 | Hold host address |
| exp_fix | input | 1 | Hold expansion address |
| irq_en | input | 1 | Master interrupt enable |
| irq_eob_en | input | 1 | Interrupt on end of block |
| irq_verr_en | input | 1 | Interrupt on verify error |
| host_base | input | 16 | Host start address |
| exp_base | input | 16 | Expansion start address, low half |
| exp_bank | input | 8 | Expansion bank |
| xfer_len | input | 16 | Byte count, 0 = 65536 |
| sh_host | input | 16 | Shadow host address |
| sh_exp | input | 16 | Shadow expansion address |
| sh_bank | input | 8 | Shadow bank |
| sh_len | input | 16 | Shadow length |
| hm_addr | output | 16 | Host memory address |
| hm_re | output | 1 | Host memory read |
| hm_we | output | 1 | Host memory write |
| hm_wdata | output | 8 | Host memory write data |
| hm_rdata | input | 8 | Host memory read data (one cycle after read) |
| xm_addr | output | 24 | Expansion memory address |
| xm_re | output | 1 | Expansion memory read |
| xm_we | output | 1 | Expansion memory write |
| xm_wdata | output | 8 | Expansion memory write data |
| xm_rdata | input | 8 | Expansion memory read data (one cycle after read) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion strobe, clears execute |
| eob_set | output | 1 | End-of-block status strobe |
| verr_set | output | 1 | Verify-error status strobe |
| irq_set | output | 1 | Interrupt-pending strobe |
| wb_host_we | output | 1 | Host address write-back enable |
| wb_host_addr | output | 16 | Host address write-back value |
| wb_exp_we | output | 1 | Expansion address and bank write-back enable |
| wb_exp_addr | output | 16 | Expansion address write-back value |
| wb_bank | output | 8 | Bank write-back value |
| wb_len_we | output | 1 | Length write-back enable |
| wb_len | output | 16 | Length write-back value |

## Verification
Copies in both directions use distinct data patterns on the two memories, so a swapped port or a stale byte shows in the contents. Exchange and compare runs tell the four operation codes apart by write counts per port and by the status strobes. A compare run with one corrupted byte checks that the run stops early, and by how much the counters advanced. Boundary runs start near 0xFFFF on the host side and at the top of the installed expansion space with an oversized bank, and the observed addresses separate wrapping from carrying. A zero-length compare that fails after 301 bytes proves the 65536 count. Held-address, autoload and interrupt-mask combinations each change exactly one group of write-back or strobe outputs.

// File: rtl/blk_dma_pkg.sv
// Shared types for the block transfer engine.
package blk_dma_pkg;

    // Operation code carried on op_sel.
    typedef enum logic [1:0] {
        OP_STORE  = 2'b00,
        OP_FETCH  = 2'b01,
        OP_SWAP   = 2'b10,
        OP_VERIFY = 2'b11
    } dma_op_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_SWP2,
        ST_FIN
    } dma_state_e;

endpackage

// File: rtl/blk_dma_addr.sv
// Address and length counters.
// Loads the host address, the masked expansion address and the byte count on
// 'load', then steps them on 'adv'. The hold flags are captured at load so a
// register change mid-transfer has no effect. Assumes EXP_SIZE_LOG2 is in
// 17..EXP_AW.
module blk_dma_addr #(
    parameter int HOST_AW       = 16,
    parameter int LEN_W         = 16,
    parameter int EXP_AW        = 24,
    parameter int EXP_SIZE_LOG2 = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               adv,
    input  logic               host_fix,
    input  logic               exp_fix,
    input  logic [HOST_AW-1:0] host_base,
    input  logic [15:0]        exp_base,
    input  logic [EXP_AW-17:0] exp_bank,
    input  logic [LEN_W-1:0]   xfer_len,
    output logic [HOST_AW-1:0] host_addr,
    output logic [EXP_AW-1:0]  exp_addr,
    output logic [LEN_W:0]     remain,
    output logic               last,
    output logic               host_held,
    output logic               exp_held
);
    localparam int REM_W = LEN_W + 1;
    localparam logic [EXP_AW-1:0] EXP_MASK = {EXP_AW{1'b1}} >> (EXP_AW - EXP_SIZE_LOG2);
    localparam logic [REM_W-1:0]  FULL_LEN = {1'b1, {LEN_W{1'b0}}};

    logic [HOST_AW-1:0] host_q;
    logic [EXP_AW-1:0]  exp_q;
    logic [REM_W-1:0]   rem_q;
    logic               hfix_q, xfix_q;

    // Counter load and per-byte step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_q <= '0;
            exp_q  <= '0;
            rem_q  <= '0;
            hfix_q <= 1'b0;
            xfix_q <= 1'b0;
        end else if (load) begin
            host_q <= host_base;
            exp_q  <= {exp_bank, exp_base} & EXP_MASK;
            rem_q  <= (xfer_len == '0) ? FULL_LEN : {1'b0, xfer_len};
            hfix_q <= host_fix;
            xfix_q <= exp_fix;
        end else if (adv) begin
            if (!hfix_q) host_q <= host_q + 1'b1;
            if (!xfix_q) exp_q  <= (exp_q + 1'b1) & EXP_MASK;
            rem_q <= rem_q - 1'b1;
        end
    end

    assign host_addr = host_q;
    assign exp_addr  = exp_q;
    assign remain    = rem_q;
    assign last      = (rem_q == REM_W'(1));
    assign host_held = hfix_q;
    assign exp_held  = xfix_q;

    // R6: a held host address never moves across a byte step.
    a_r6_host_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && hfix_q) |=> $stable(host_q));

    // R6: a held expansion address never moves across a byte step.
    a_r6_exp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && xfix_q) |=> $stable(exp_q));

endmodule

// File: rtl/blk_dma_seq.sv
// Transfer sequencer.
// One read cycle fetches the bytes a step needs. The next cycle writes or
// compares them. A swap adds a second write cycle with the expansion byte
// held in a temporary register. Memories return read data one cycle after
// the read strobe. The operation is latched at start.
module blk_dma_seq
    import blk_dma_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_sel,
    input  logic              last,
    input  logic [DATA_W-1:0] hm_rdata,
    input  logic [DATA_W-1:0] xm_rdata,
    output logic              load,
    output logic              adv,
    output logic              hm_re,
    output logic              hm_we,
    output logic [DATA_W-1:0] hm_wdata,
    output logic              xm_re,
    output logic              xm_we,
    output logic [DATA_W-1:0] xm_wdata,
    output logic              busy,
    output logic              done,
    output logic              eob,
    output logic              verr
);
    dma_state_e        state_q, state_d;
    dma_op_e           op_q;
    logic [DATA_W-1:0] tmp_q;
    logic              eob_q, verr_q;
    logic              set_eob, set_verr, cap_tmp;

    assign load = start && (state_q == ST_IDLE);

    // State, latched operation, swap byte and outcome flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_STORE;
            tmp_q   <= '0;
            eob_q   <= 1'b0;
            verr_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                op_q   <= dma_op_e'(op_sel);
                eob_q  <= 1'b0;
                verr_q <= 1'b0;
            end
            if (set_eob)  eob_q  <= 1'b1;
            if (set_verr) verr_q <= 1'b1;
            if (cap_tmp)  tmp_q  <= xm_rdata;
        end
    end

    // Next state and memory strobes for the current step.
    always_comb begin
        state_d  = state_q;
        adv      = 1'b0;
        hm_re    = 1'b0;
        xm_re    = 1'b0;
        hm_we    = 1'b0;
        xm_we    = 1'b0;
        hm_wdata = '0;
        xm_wdata = '0;
        set_eob  = 1'b0;
        set_verr = 1'b0;
        cap_tmp  = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RD;
            ST_RD: begin
                hm_re   = (op_q != OP_FETCH);
                xm_re   = (op_q != OP_STORE);
                state_d = ST_WR;
            end
            ST_WR: begin
                case (op_q)
                    OP_STORE: begin
                        xm_we    = 1'b1;
                        xm_wdata = hm_rdata;
                        adv      = 1'b1;
                        set_eob  = last;
                        state_d  = last ? ST_FIN : ST_RD;
                    end
                    OP_FETCH: begin
                        hm_we    = 1'b1;
                        hm_wdata = xm_rdata;
                        adv      = 1'b1;
                        set_eob  = last;
                        state_d  = last ? ST_FIN : ST_RD;
                    end
                    OP_SWAP: begin
                        xm_we    = 1'b1;
                        xm_wdata = hm_rdata;
                        cap_tmp  = 1'b1;
                        state_d  = ST_SWP2;
                    end
                    default: begin
                        adv = 1'b1;
                        if (hm_rdata != xm_rdata) begin
                            set_verr = 1'b1;
                            state_d  = ST_FIN;
                        end else begin
                            set_eob = last;
                            state_d = last ? ST_FIN : ST_RD;
                        end
                    end
                endcase
            end
            ST_SWP2: begin
                hm_we    = 1'b1;
                hm_wdata = tmp_q;
                adv      = 1'b1;
                set_eob  = last;
                state_d  = last ? ST_FIN : ST_RD;
            end
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_FIN);
    assign eob  = eob_q;
    assign verr = verr_q;

    // R12: no memory traffic while idle.
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !(hm_re || xm_re || hm_we || xm_we));

    // R10: completion is a single-cycle strobe.
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: an expansion write of a swap is followed by the host write.
    a_r2_swap_order: assert property (@(posedge clk) disable iff (!rst_n)
        (xm_we && op_q == OP_SWAP) |=> hm_we);

    // R4: a transfer ends with either outcome, never both.
    a_r4_outcome_excl: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(eob_q && verr_q));

endmodule

// File: rtl/blk_dma_report.sv
// End-of-transfer reporting.
// In the completion cycle it selects the write-back values (final counters or
// shadows) and forms the status and interrupt strobes from the latched
// outcome and the live mask inputs. Purely combinational.
module blk_dma_report #(
    parameter int HOST_AW = 16,
    parameter int LEN_W   = 16,
    parameter int EXP_AW  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               done,
    input  logic               eob,
    input  logic               verr,
    input  logic               autoload,
    input  logic               irq_en,
    input  logic               irq_eob_en,
    input  logic               irq_verr_en,
    input  logic               host_held,
    input  logic               exp_held,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [EXP_AW-1:0]  exp_addr,
    input  logic [LEN_W:0]     remain,
    input  logic [HOST_AW-1:0] sh_host,
    input  logic [15:0]        sh_exp,
    input  logic [EXP_AW-17:0] sh_bank,
    input  logic [LEN_W-1:0]   sh_len,
    output logic               eob_set,
    output logic               verr_set,
    output logic               irq_set,
    output logic               wb_host_we,
    output logic [HOST_AW-1:0] wb_host_addr,
    output logic               wb_exp_we,
    output logic [15:0]        wb_exp_addr,
    output logic [EXP_AW-17:0] wb_bank,
    output logic               wb_len_we,
    output logic [LEN_W-1:0]   wb_len
);
    logic [LEN_W-1:0] end_len;

    // Length left after the run; a finished block reports 1.
    always_comb begin
        end_len = (remain == '0) ? LEN_W'(1) : remain[LEN_W-1:0];
    end

    // Write-back selection: shadows under autoload, end values otherwise.
    always_comb begin
        wb_host_we   = done && (autoload || !host_held);
        wb_exp_we    = done && (autoload || !exp_held);
        wb_len_we    = done;
        wb_host_addr = autoload ? sh_host : host_addr;
        wb_exp_addr  = autoload ? sh_exp  : exp_addr[15:0];
        wb_bank      = autoload ? sh_bank : exp_addr[EXP_AW-1:16];
        wb_len       = autoload ? sh_len  : end_len;
    end

    // Status and interrupt strobes.
    always_comb begin
        eob_set  = done && eob;
        verr_set = done && verr;
        irq_set  = done && irq_en && ((eob && irq_eob_en) || (verr && irq_verr_en));
    end

    // R11: an interrupt needs completion and the master enable.
    a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |-> (done && irq_en));

    // R8: without autoload the written length is never zero.
    a_r8_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_len_we && !autoload) |-> (wb_len != '0));

endmodule

// File: rtl/blk_dma_engine.sv
// Block transfer DMA engine, top level.
// Joins the sequencer, the address/length counters and the reporting logic.
// Assumes both memory ports answer a read on the next cycle and accept a
// write in the cycle it is strobed, with no wait states.
module blk_dma_engine #(
    parameter int HOST_AW       = 16,
    parameter int LEN_W         = 16,
    parameter int EXP_AW        = 24,
    parameter int EXP_SIZE_LOG2 = 19,
    parameter int DATA_W        = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         op_sel,
    input  logic               autoload,
    input  logic               host_fix,
    input  logic               exp_fix,
    input  logic               irq_en,
    input  logic               irq_eob_en,
    input  logic               irq_verr_en,
    input  logic [HOST_AW-1:0] host_base,
    input  logic [15:0]        exp_base,
    input  logic [EXP_AW-17:0] exp_bank,
    input  logic [LEN_W-1:0]   xfer_len,
    input  logic [HOST_AW-1:0] sh_host,
    input  logic [15:0]        sh_exp,
    input  logic [EXP_AW-17:0] sh_bank,
    input  logic [LEN_W-1:0]   sh_len,
    output logic [HOST_AW-1:0] hm_addr,
    output logic               hm_re,
    output logic               hm_we,
    output logic [DATA_W-1:0]  hm_wdata,
    input  logic [DATA_W-1:0]  hm_rdata,
    output logic [EXP_AW-1:0]  xm_addr,
    output logic               xm_re,
    output logic               xm_we,
    output logic [DATA_W-1:0]  xm_wdata,
    input  logic [DATA_W-1:0]  xm_rdata,
    output logic               busy,
    output logic               done,
    output logic               eob_set,
    output logic               verr_set,
    output logic               irq_set,
    output logic               wb_host_we,
    output logic [HOST_AW-1:0] wb_host_addr,
    output logic               wb_exp_we,
    output logic [15:0]        wb_exp_addr,
    output logic [EXP_AW-17:0] wb_bank,
    output logic               wb_len_we,
    output logic [LEN_W-1:0]   wb_len
);
    logic             load, adv, last, eob, verr, host_held, exp_held;
    logic [LEN_W:0]   remain;

    blk_dma_seq #(.DATA_W(DATA_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .last(last),
        .hm_rdata(hm_rdata), .xm_rdata(xm_rdata), .load(load), .adv(adv),
        .hm_re(hm_re), .hm_we(hm_we), .hm_wdata(hm_wdata),
        .xm_re(xm_re), .xm_we(xm_we), .xm_wdata(xm_wdata),
        .busy(busy), .done(done), .eob(eob), .verr(verr)
    );

    blk_dma_addr #(
        .HOST_AW(HOST_AW), .LEN_W(LEN_W), .EXP_AW(EXP_AW), .EXP_SIZE_LOG2(EXP_SIZE_LOG2)
    ) addr_i (
        .clk(clk), .rst_n(rst_n), .load(load), .adv(adv),
        .host_fix(host_fix), .exp_fix(exp_fix), .host_base(host_base),
        .exp_base(exp_base), .exp_bank(exp_bank), .xfer_len(xfer_len),
        .host_addr(hm_addr), .exp_addr(xm_addr), .remain(remain), .last(last),
        .host_held(host_held), .exp_held(exp_held)
    );

    blk_dma_report #(.HOST_AW(HOST_AW), .LEN_W(LEN_W), .EXP_AW(EXP_AW)) report_i (
        .clk(clk), .rst_n(rst_n), .done(done), .eob(eob), .verr(verr),
        .autoload(autoload), .irq_en(irq_en), .irq_eob_en(irq_eob_en),
        .irq_verr_en(irq_verr_en), .host_held(host_held), .exp_held(exp_held),
        .host_addr(hm_addr), .exp_addr(xm_addr), .remain(remain),
        .sh_host(sh_host), .sh_exp(sh_exp), .sh_bank(sh_bank), .sh_len(sh_len),
        .eob_set(eob_set), .verr_set(verr_set), .irq_set(irq_set),
        .wb_host_we(wb_host_we), .wb_host_addr(wb_host_addr),
        .wb_exp_we(wb_exp_we), .wb_exp_addr(wb_exp_addr), .wb_bank(wb_bank),
        .wb_len_we(wb_len_we), .wb_len(wb_len)
    );

    // R10: completion always leaves the engine idle on the next cycle.
    a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: tb/blk_dma_engine_tb_top.sv
`timescale 1ns/1ps
module blk_dma_engine_tb_top;
    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [1:0] op_sel;
    logic autoload, host_fix, exp_fix, irq_en, irq_eob_en, irq_verr_en;
    logic [15:0] host_base, exp_base, xfer_len, sh_host, sh_exp, sh_len;
    logic [7:0]  exp_bank, sh_bank;
    logic [15:0] hm_addr; logic hm_re, hm_we; logic [7:0] hm_wdata, hm_rdata;
    logic [23:0] xm_addr; logic xm_re, xm_we; logic [7:0] xm_wdata, xm_rdata;
    logic busy, done, eob_set, verr_set, irq_set;
    logic wb_host_we, wb_exp_we, wb_len_we;
    logic [15:0] wb_host_addr, wb_exp_addr, wb_len;
    logic [7:0]  wb_bank;

    always #2.5 clk = ~clk;

    blk_dma_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .autoload(autoload),
        .host_fix(host_fix), .exp_fix(exp_fix), .irq_en(irq_en), .irq_eob_en(irq_eob_en),
        .irq_verr_en(irq_verr_en), .host_base(host_base), .exp_base(exp_base),
        .exp_bank(exp_bank), .xfer_len(xfer_len), .sh_host(sh_host), .sh_exp(sh_exp),
        .sh_bank(sh_bank), .sh_len(sh_len), .hm_addr(hm_addr), .hm_re(hm_re),
        .hm_we(hm_we), .hm_wdata(hm_wdata), .hm_rdata(hm_rdata), .xm_addr(xm_addr),
        .xm_re(xm_re), .xm_we(xm_we), .xm_wdata(xm_wdata), .xm_rdata(xm_rdata),
        .busy(busy), .done(done), .eob_set(eob_set), .verr_set(verr_set),
        .irq_set(irq_set), .wb_host_we(wb_host_we), .wb_host_addr(wb_host_addr),
        .wb_exp_we(wb_exp_we), .wb_exp_addr(wb_exp_addr), .wb_bank(wb_bank),
        .wb_len_we(wb_len_we), .wb_len(wb_len)
    );

    // Small memory models indexed by the low 12 address bits.
    logic [7:0] hmem [0:4095];
    logic [7:0] xmem [0:4095];
    always @(posedge clk) begin
        if (hm_we) hmem[hm_addr[11:0]] <= hm_wdata;
        if (xm_we) xmem[xm_addr[11:0]] <= xm_wdata;
        hm_rdata <= hmem[hm_addr[11:0]];
        xm_rdata <= xmem[xm_addr[11:0]];
    end

    int n_chk = 0, n_fail = 0;
    int n_hwe, n_xwe, n_hre, n_done;
    logic [23:0] first_xa, last_xa;

    // Strobe monitor, sampled between edges.
    always @(negedge clk) begin
        if (hm_we) n_hwe++;
        if (hm_re) n_hre++;
        if (done)  n_done++;
        if (xm_we) begin
            if (n_xwe == 0) first_xa = xm_addr;
            last_xa = xm_addr;
            n_xwe++;
        end
    end

    logic c_hwe, c_xwe, c_lwe, c_eob, c_verr, c_irq, post_done, post_busy;
    logic [15:0] c_host, c_exp, c_len;
    logic [7:0]  c_bank;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic defaults();
        op_sel = 2'b00; autoload = 0; host_fix = 0; exp_fix = 0;
        irq_en = 0; irq_eob_en = 0; irq_verr_en = 0;
        host_base = 0; exp_base = 0; exp_bank = 0; xfer_len = 1;
        sh_host = 0; sh_exp = 0; sh_bank = 0; sh_len = 0;
    endtask

    task automatic fill();
        for (int i = 0; i < 4096; i++) begin
            hmem[i] = 8'(i * 7 + 3);
            xmem[i] = 8'(i * 13 + 5);
        end
    endtask

    // Pulse start, wait for completion, capture the completion cycle.
    task automatic launch();
        int cyc;
        n_hwe = 0; n_xwe = 0; n_hre = 0; n_done = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R10: actual no done expected done");
        end
        c_hwe = wb_host_we; c_host = wb_host_addr; c_xwe = wb_exp_we;
        c_exp = wb_exp_addr; c_bank = wb_bank; c_lwe = wb_len_we; c_len = wb_len;
        c_eob = eob_set; c_verr = verr_set; c_irq = irq_set;
        @(negedge clk);
        post_done = done; post_busy = busy;
    endtask

    task automatic t_reset();
        chk("R12 busy", busy, 0);
        chk("R12 done", done, 0);
        chk("R12 strobes", {hm_re, hm_we, xm_re, xm_we}, 0);
    endtask

    task automatic t_store();
        int bad = 0;
        defaults(); fill();
        host_base = 16'h0100; exp_base = 16'h0200; exp_bank = 8'h01; xfer_len = 8;
        irq_en = 1; irq_eob_en = 1;
        launch();
        for (int i = 0; i < 8; i++) if (xmem[12'h200 + i] !== hmem[12'h100 + i]) bad++;
        chk("R1 store data", bad, 0);
        chk("R8 host wb", {c_hwe, c_host}, {1'b1, 16'h0108});
        chk("R8 exp wb", {c_xwe, c_bank, c_exp}, {1'b1, 8'h01, 16'h0208});
        chk("R8 len wb", {c_lwe, c_len}, {1'b1, 16'h0001});
        chk("R11 eob irq", {c_eob, c_verr, c_irq}, 3'b101);
    endtask

    task automatic t_fetch_fixed();
        int bad = 0;
        defaults(); fill();
        op_sel = 2'b01; exp_fix = 1; exp_base = 16'h0300; exp_bank = 8'h02;
        host_base = 16'h0400; xfer_len = 4;
        launch();
        for (int i = 0; i < 4; i++) if (hmem[12'h400 + i] !== xmem[12'h300]) bad++;
        chk("R1 fetch data R6 exp hold", bad, 0);
        chk("R1 fetch write counts", {n_hwe[7:0], n_xwe[7:0]}, {8'd4, 8'd0});
        chk("R8 exp held no wb", c_xwe, 0);
        chk("R8 fetch host wb", {c_hwe, c_host}, {1'b1, 16'h0404});
    endtask

    task automatic t_swap();
        logic [7:0] h0 [4]; logic [7:0] x0 [4];
        int bad = 0;
        defaults(); fill();
        op_sel = 2'b10; host_base = 16'h0D00; exp_base = 16'h0E00; xfer_len = 4;
        for (int i = 0; i < 4; i++) begin h0[i] = hmem[12'hD00 + i]; x0[i] = xmem[12'hE00 + i]; end
        launch();
        for (int i = 0; i < 4; i++) begin
            if (hmem[12'hD00 + i] !== x0[i]) bad++;
            if (xmem[12'hE00 + i] !== h0[i]) bad++;
        end
        chk("R2 swap data", bad, 0);
        chk("R2 swap write counts", {n_hwe[7:0], n_xwe[7:0]}, {8'd4, 8'd4});
        chk("R2 swap eob", c_eob, 1);
    endtask

    task automatic t_verify_ok();
        defaults(); fill();
        op_sel = 2'b11; host_base = 16'h0F00; exp_base = 16'h0F80; xfer_len = 5;
        irq_en = 1; irq_verr_en = 1;
        for (int i = 0; i < 5; i++) xmem[12'hF80 + i] = hmem[12'hF00 + i];
        launch();
        chk("R3 verify outcome", {c_eob, c_verr}, 2'b10);
        chk("R3 verify no writes", n_hwe + n_xwe, 0);
        chk("R11 eob masked", c_irq, 0);
        chk("R8 verify len", c_len, 1);
    endtask

    task automatic t_verify_bad();
        defaults(); fill();
        op_sel = 2'b11; host_base = 16'h0A00; exp_base = 16'h0B00; xfer_len = 6;
        irq_en = 1; irq_verr_en = 1;
        for (int i = 0; i < 6; i++) xmem[12'hB00 + i] = hmem[12'hA00 + i];
        xmem[12'hB02] = ~hmem[12'hA02];
        launch();
        chk("R4 mismatch outcome", {c_eob, c_verr}, 2'b01);
        chk("R4 reads stop", n_hre, 3);
        chk("R4 addr wb", {c_host, c_exp}, {16'h0A03, 16'h0B03});
        chk("R4 remaining len", c_len, 3);
        chk("R11 verr irq", c_irq, 1);
    endtask

    task automatic t_len_zero();
        defaults(); fill();
        op_sel = 2'b11; xfer_len = 0; irq_verr_en = 1;
        for (int i = 0; i < 4096; i++) xmem[i] = hmem[i];
        xmem[300] = hmem[300] ^ 8'h01;
        launch();
        chk("R5 zero length remaining", c_len, 16'd65235);
        chk("R5 zero length host", c_host, 16'h012D);
        chk("R11 verr without master", {c_verr, c_irq}, 2'b10);
    endtask

    task automatic t_host_wrap();
        int bad = 0;
        defaults(); fill();
        host_base = 16'hFFFE; exp_base = 16'h0900; xfer_len = 4;
        launch();
        for (int i = 0; i < 4; i++) if (xmem[12'h900 + i] !== hmem[12'(12'hFFE + i)]) bad++;
        chk("R6 host wrap data", bad, 0);
        chk("R6 host wrap wb", c_host, 16'h0002);
    endtask

    task automatic t_host_fixed();
        int bad = 0;
        defaults(); fill();
        host_fix = 1; host_base = 16'h0A10; exp_base = 16'h0C00; xfer_len = 3;
        launch();
        for (int i = 0; i < 3; i++) if (xmem[12'hC00 + i] !== hmem[12'hA10]) bad++;
        chk("R6 host hold data", bad, 0);
        chk("R8 host held no wb", c_hwe, 0);
        chk("R8 exp wb stepped", c_exp, 16'h0C03);
    endtask

    task automatic t_bank_wrap();
        defaults(); fill();
        host_base = 16'h0800; exp_base = 16'hFFFE; exp_bank = 8'hFF; xfer_len = 4;
        launch();
        chk("R7 first exp addr", first_xa, 24'h07FFFE);
        chk("R7 last exp addr", last_xa, 24'h000001);
        chk("R7 wrap data", {xmem[12'hFFE], xmem[0]}, {hmem[12'h800], hmem[12'h802]});
        chk("R7 bank wb", {c_bank, c_exp}, {8'h00, 16'h0002});
    endtask

    task automatic t_autoload();
        defaults(); fill();
        autoload = 1; host_fix = 1; host_base = 16'h0300; exp_base = 16'h0380; xfer_len = 2;
        sh_host = 16'h1234; sh_exp = 16'h5678; sh_bank = 8'h9A; sh_len = 16'h0BCD;
        launch();
        chk("R9 enables", {c_hwe, c_xwe, c_lwe}, 3'b111);
        chk("R9 host shadow", c_host, 16'h1234);
        chk("R9 exp shadow", {c_bank, c_exp}, {8'h9A, 16'h5678});
        chk("R9 len shadow", c_len, 16'h0BCD);
    endtask

    task automatic t_busy_start();
        int bad = 0;
        defaults(); fill();
        host_base = 16'h0600; exp_base = 16'h0700; xfer_len = 6;
        n_hwe = 0; n_xwe = 0; n_done = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        op_sel = 2'b01; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk("R10 done one cycle", {done, busy}, 2'b00);
        repeat (6) @(negedge clk);
        chk("R10 single completion", n_done, 1);
        chk("R10 second start ignored", {n_hwe[7:0], n_xwe[7:0]}, {8'd0, 8'd6});
        for (int i = 0; i < 6; i++) if (xmem[12'h700 + i] !== hmem[12'h600 + i]) bad++;
        chk("R10 data intact", bad, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL R10 watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        defaults();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store();
        t_fetch_fixed();
        t_swap();
        t_verify_ok();
        t_verify_bad();
        t_len_zero();
        t_host_wrap();
        t_host_fixed();
        t_bank_wrap();
        t_autoload();
        t_busy_start();
        chk("R10 final idle", busy, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule